// File: doc/BRIEF.md
# Receive IP Checksum Verifier

This block watches a receive byte stream that carries one Ethernet frame at a time and checks the frame's IP checksums while the bytes go past. It buffers nothing. Each byte is qualified by `in_valid`. `in_sof` marks the first byte of a frame and `in_eof` marks the last. The block reads the EtherType, parses an IPv4 or IPv6 header, and keeps running 16-bit one's-complement sums: one over the IPv4 header, one over the layer-4 segment, and one over the addresses that a pseudo-header needs.

When the frame ends, the block presents one result word for a single cycle. The word holds the network-layer type, the layer-4 protocol number, a header-checksum error flag, a layer-4 checksum error flag, and a flag that says whether a layer-4 check was actually made. Multi-byte fields are big-endian. The IP header begins `ETH_HDR` bytes into the frame, and the EtherType occupies the two bytes just before it.

Top module: `rx_csum_check`

## Requirements
- R1: The EtherType selects the layer 3 type. 0x0800 gives `res_l3`=01 (IPv4), 0x86DD gives 10 (IPv6), and any other value gives 00. With 00, `res_l4`, `res_checked`, `res_hdr_err` and `res_l4_err` are all 0.
- R2: `res_valid` is high for exactly one cycle: the cycle that follows the clock edge that takes the `in_eof` byte. While `res_valid` is low, all result outputs are 0.
- R3: For IPv4, the header is IHL×4 bytes, where IHL is the low nibble of IP byte 0. The header sum is folded to 16 bits, and the header counts as good only when the folded value is 0xFFFF. Otherwise `res_hdr_err` is 1.
- R4: `res_hdr_err` is never 1 for an IPv6 frame.
- R5: `res_l4` reports the protocol number: IPv4 byte 9, or the IPv6 next-header field at byte 6. Layer-4 sums are verified for TCP (6), UDP (17), ICMP (1) and IGMP (2) over IPv4, and for TCP, UDP and ICMPv6 (58) over IPv6. A failing sum sets `res_l4_err`.
- R6: A pseudo-header is added for TCP and UDP, and for every IPv6 protocol. Over IPv4 it is the source and destination addresses (IP bytes 12–19), the protocol, and the length (total length minus IHL×4). Over IPv6 it is the addresses (IP bytes 8–39), the payload length, and the next header. ICMP and IGMP over IPv4 use no pseudo-header.
- R7: An IPv4 packet with MF set (bit 5 of IP byte 6) or with a nonzero 13-bit fragment offset gives `res_checked`=0 and `res_l4_err`=0, even when the segment bytes are wrong.
- R8: A UDP checksum field of zero (segment bytes 6–7) over IPv4 means "no checksum": `res_checked`=0 and `res_l4_err`=0. The same zero field over IPv6 gives `res_checked`=1 and `res_l4_err`=1.
- R9: A segment of odd length is summed with its last byte as a high byte and a zero low byte. Bytes beyond the IPv4 total length or the IPv6 payload length, such as padding or an FCS, do not affect the results.
- R10: A protocol outside the R5 set gives `res_checked`=0 and `res_l4_err`=0.
- R11: While reset is asserted, and after it is released until a frame ends, `res_valid` is 0.
- R12: Cycles with `in_valid` low inside a frame are ignored; they do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte qualifier |
| in_sof | input | 1 | First byte of frame (with in_valid) |
| in_eof | input | 1 | Last byte of frame (with in_valid) |
| in_data | input | 8 | Frame byte |
| res_valid | output | 1 | Result strobe, one cycle |
| res_l3 | output | 2 | 00 none, 01 IPv4, 10 IPv6 |
| res_l4 | output | 8 | Layer 4 protocol number |
| res_hdr_err | output | 1 | IPv4 header checksum wrong |
| res_l4_err | output | 1 | Layer 4 checksum wrong |
| res_checked | output | 1 | A layer 4 check was made |

## Verification
The assertions assume that `in_sof` and `in_eof` matter only when `in_valid` is high, and that each frame starts with an `in_sof` byte. They also assume that the header length and packet length fields describe a packet that fits inside the frame.

The stimulus meets these assumptions. Every frame is built by a generator that writes consistent length fields, puts the checksums in their proper places, and then corrupts single chosen bytes. Frames are sent with idle gaps, and in one case with a bubble inside the frame, so the checks never rely on back-to-back frames.

// File: rtl/rx_csum_check.sv
module rx_csum_check #(
  parameter int ETH_HDR = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  output logic       res_valid,
  output logic [1:0] res_l3,
  output logic [7:0] res_l4,
  output logic       res_hdr_err,
  output logic       res_l4_err,
  output logic       res_checked
);
  localparam logic [15:0] IP_AT = 16'(ETH_HDR);
  localparam logic [15:0] ET_AT = 16'(ETH_HDR - 2);

  logic [15:0] pos, etype, tlen;
  logic [5:0]  hlen;
  logic [7:0]  proto;
  logic        frag, cknz, done;
  logic [31:0] hsum, asum, dsum;

  function automatic logic [15:0] fold(input logic [31:0] a);
    logic [16:0] f;
    f = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    return f[15:0] + {15'd0, f[16]};
  endfunction

  wire        v4    = etype == 16'h0800;
  wire        v6    = etype == 16'h86DD;
  wire [15:0] o     = pos - IP_AT;
  wire        ip_b  = (pos >= IP_AT) && (v4 || v6);
  wire [15:0] hend  = v6 ? 16'd40 : {10'd0, hlen};
  wire [16:0] lend  = v6 ? 17'd40 + {1'b0, tlen} : {1'b0, tlen};
  wire [15:0] lo    = o - hend;
  wire        in_l4 = ip_b && (o >= hend) && ({1'b0, o} < lend);
  wire        in_hd = ip_b && v4 && (o == 16'd0 || o < hend);
  wire        in_ad = ip_b && (v4 ? (o >= 16'd12 && o < 16'd20) : (o >= 16'd8 && o < 16'd40));
  wire [31:0] wv    = {16'd0, o[0] ? {8'h00, in_data} : {in_data, 8'h00}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; etype <= '0; tlen <= '0; hlen <= '0; proto <= '0;
      frag <= 1'b0; cknz <= 1'b0; done <= 1'b0;
      hsum <= '0; asum <= '0; dsum <= '0;
    end else begin
      done <= in_valid && in_eof;
      if (in_valid) begin
        if (in_sof) begin
          pos <= 16'd1; etype <= '0; tlen <= '0; hlen <= '0; proto <= '0;
          frag <= 1'b0; cknz <= 1'b0;
          hsum <= '0; asum <= '0; dsum <= '0;
        end else begin
          if (pos != 16'hFFFF) pos <= pos + 16'd1;
          if (pos == ET_AT)         etype[15:8] <= in_data;
          if (pos == ET_AT + 16'd1) etype[7:0]  <= in_data;
          if (ip_b && v4) begin
            if (o == 16'd0) hlen <= {in_data[3:0], 2'b00};
            if (o == 16'd2) tlen[15:8] <= in_data;
            if (o == 16'd3) tlen[7:0]  <= in_data;
            if (o == 16'd6) frag <= in_data[5] || (in_data[4:0] != 5'd0);
            if (o == 16'd7) frag <= frag || (in_data != 8'd0);
            if (o == 16'd9) proto <= in_data;
          end
          if (ip_b && v6) begin
            if (o == 16'd4) tlen[15:8] <= in_data;
            if (o == 16'd5) tlen[7:0]  <= in_data;
            if (o == 16'd6) proto <= in_data;
          end
          if (in_hd) hsum <= hsum + wv;
          if (in_ad) asum <= asum + wv;
          if (in_l4) begin
            dsum <= dsum + wv;
            if ((lo == 16'd6 || lo == 16'd7) && in_data != 8'd0) cknz <= 1'b1;
          end
        end
      end
    end
  end

  wire        tcp   = proto == 8'd6;
  wire        udp   = proto == 8'd17;
  wire        sup   = v4 ? (tcp || udp || proto == 8'd1 || proto == 8'd2)
                         : (v6 && (tcp || udp || proto == 8'd58));
  wire        psh   = v6 || tcp || udp;
  wire [15:0] l4len = v6 ? tlen : tlen - {10'd0, hlen};
  wire [31:0] tot   = dsum + (psh ? asum + {24'd0, proto} + {16'd0, l4len} : 32'd0);
  wire        udp0  = udp && !cknz;
  wire        chk   = sup && !(v4 && frag) && !(v4 && udp0);
  wire        l4bad = chk && ((v6 && udp0) || fold(tot) != 16'hFFFF);
  wire        hbad  = v4 && fold(hsum) != 16'hFFFF;

  assign res_valid   = done;
  assign res_l3      = done ? {v6, v4} : 2'b00;
  assign res_l4      = (done && (v4 || v6)) ? proto : 8'd0;
  assign res_hdr_err = done && hbad;
  assign res_l4_err  = done && l4bad;
  assign res_checked = done && chk;
endmodule

// File: rtl/rx_csum_check_props.sv
module rx_csum_check_props (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_eof,
  input logic       res_valid,
  input logic [1:0] res_l3,
  input logic [7:0] res_l4,
  input logic       res_hdr_err,
  input logic       res_l4_err,
  input logic       res_checked
);
  assert_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_l3 == 2'b00 && res_l4 == 8'd0 && !res_hdr_err && !res_l4_err && !res_checked));
  assert_l3_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_l3 != 2'b11);
  assert_non_ip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_l3 == 2'b00) |-> (!res_checked && !res_hdr_err && !res_l4_err && res_l4 == 8'd0));
  assert_v6_no_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_l3 == 2'b10) |-> !res_hdr_err);
  assert_err_needs_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_l4_err |-> res_checked);
endmodule

bind rx_csum_check rx_csum_check_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .res_valid(res_valid), .res_l3(res_l3), .res_l4(res_l4),
  .res_hdr_err(res_hdr_err), .res_l4_err(res_l4_err), .res_checked(res_checked)
);

// File: tb/rx_csum_check_test.sv
`timescale 1ns/1ps
module rx_csum_check_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic res_valid, res_hdr_err, res_l4_err, res_checked;
  logic [1:0] res_l3;
  logic [7:0] res_l4;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rx_csum_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .res_valid(res_valid), .res_l3(res_l3), .res_l4(res_l4),
    .res_hdr_err(res_hdr_err), .res_l4_err(res_l4_err), .res_checked(res_checked)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  proto;
    logic [15:0] l4len;
    logic [3:0]  ihl;
    logic [1:0]  frag;
    logic        bad_hdr;
    logic        bad_l4;
    logic        zero_ck;
    logic [3:0]  pad;
    logic        e_chk;
    logic        e_hdr;
    logic        e_l4;
  } tv_t;

  localparam int NV = 19;
  localparam tv_t TV [NV] = '{
    '{2'd1, 8'd6,  16'd40, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd17, 16'd23, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd1,  16'd32, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd2,  16'd8,  4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd6,  16'd21, 4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd17, 16'd20, 4'd5, 2'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0},
    '{2'd1, 8'd6,  16'd40, 4'd5, 2'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1},
    '{2'd1, 8'd1,  16'd15, 4'd5, 2'd0, 1'b0, 1'b1, 1'b0, 4'd5, 1'b1, 1'b0, 1'b1},
    '{2'd1, 8'd17, 16'd20, 4'd5, 2'd1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'd6,  16'd30, 4'd5, 2'd2, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'd17, 16'd20, 4'd5, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'd17, 16'd20, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0, 1'b1},
    '{2'd2, 8'd6,  16'd33, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd4, 1'b1, 1'b0, 1'b0},
    '{2'd2, 8'd58, 16'd16, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 8'd17, 16'd24, 4'd0, 2'd0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1},
    '{2'd2, 8'd58, 16'd16, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 8'd6,  16'd40, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 8'd50, 16'd20, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'd1,  16'd20, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  logic [7:0] frm [0:299];
  int n;

  function automatic int unsigned osum(input int s, input int c);
    int unsigned acc = 0;
    for (int k = s; k < s + c; k++)
      acc += ((k - 14) % 2 == 0) ? {16'd0, frm[k], 8'd0} : {24'd0, frm[k]};
    return acc;
  endfunction

  function automatic logic [15:0] fold16(input int unsigned a);
    int unsigned f = (a & 32'hFFFF) + (a >> 16);
    f = (f & 32'hFFFF) + (f >> 16);
    return f[15:0];
  endfunction

  task automatic build(input tv_t t);
    int hl, l4s, tot, ckoff;
    int unsigned acc;
    logic [15:0] c;
    for (int i = 0; i < 12; i++) frm[i] = 8'(8'hA0 + i);
    hl = (t.kind == 2'd2) ? 40 : int'(t.ihl) * 4;
    frm[12] = (t.kind == 2'd2) ? 8'h86 : 8'h08;
    frm[13] = (t.kind == 2'd2) ? 8'hDD : ((t.kind == 2'd1) ? 8'h00 : 8'h06);
    for (int i = 0; i < hl; i++) frm[14 + i] = 8'h00;
    l4s = 14 + hl;
    n = l4s + int'(t.l4len) + int'(t.pad);
    if (t.kind != 2'd2) begin
      tot = hl + int'(t.l4len);
      frm[14] = {4'h4, t.ihl};
      frm[16] = 8'(tot >> 8); frm[17] = 8'(tot);
      frm[18] = 8'h12; frm[19] = 8'h34;
      frm[20] = (t.frag == 2'd1) ? 8'h20 : 8'h00;
      frm[21] = (t.frag == 2'd2) ? 8'h10 : 8'h00;
      frm[22] = 8'd64; frm[23] = t.proto;
      for (int i = 0; i < 8; i++) frm[26 + i] = 8'(8'hC0 + 13 * i);
      for (int i = 20; i < hl; i++) frm[14 + i] = 8'h01;
    end else begin
      frm[14] = 8'h60;
      frm[18] = t.l4len[15:8]; frm[19] = t.l4len[7:0];
      frm[20] = t.proto; frm[21] = 8'hFF;
      for (int i = 0; i < 32; i++) frm[22 + i] = 8'(8'h20 + 7 * i);
    end
    for (int i = 0; i < int'(t.l4len); i++) frm[l4s + i] = 8'(i * 29 + 91 + int'(t.proto));
    for (int i = 0; i < int'(t.pad); i++) frm[l4s + int'(t.l4len) + i] = 8'hEE;
    ckoff = (t.proto == 8'd6) ? 16 : ((t.proto == 8'd17) ? 6 : 2);
    frm[l4s + ckoff] = 8'h00; frm[l4s + ckoff + 1] = 8'h00;
    acc = osum(l4s, int'(t.l4len));
    if (t.kind == 2'd2 || t.proto == 8'd6 || t.proto == 8'd17)
      acc += osum((t.kind == 2'd2) ? 22 : 26, (t.kind == 2'd2) ? 32 : 8) + t.proto + t.l4len;
    c = ~fold16(acc);
    if (t.proto == 8'd17 && c == 16'd0) c = 16'hFFFF;
    if (t.zero_ck) c = 16'd0;
    frm[l4s + ckoff] = c[15:8]; frm[l4s + ckoff + 1] = c[7:0];
    if (t.kind != 2'd2) begin
      c = ~fold16(osum(14, hl));
      frm[24] = c[15:8]; frm[25] = c[7:0];
    end
    if (t.bad_hdr) begin
      if (t.kind == 2'd2) frm[21] = frm[21] ^ 8'h01;
      else frm[22] = frm[22] ^ 8'h01;
    end
    if (t.bad_l4) frm[l4s + int'(t.l4len) - 1] = frm[l4s + int'(t.l4len) - 1] ^ 8'h04;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit bubble);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bubble && i == 20) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h5A;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = frm[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
  endtask

  task automatic expect_res(input tv_t t, input string tag);
    check({tag, " R2 valid"}, int'(res_valid), 1);
    check({tag, " R1 l3"}, int'(res_l3), int'(t.kind));
    check({tag, " R5 proto"}, int'(res_l4), (t.kind == 2'd0) ? 0 : int'(t.proto));
    check({tag, " R3 R4 hdr_err"}, int'(res_hdr_err), int'(t.e_hdr));
    check({tag, " R6 R7 R8 R10 checked"}, int'(res_checked), int'(t.e_chk));
    check({tag, " R5 R9 l4_err"}, int'(res_l4_err), int'(t.e_l4));
    @(negedge clk);
    check({tag, " R2 one cycle"}, int'(res_valid), 0);
    check({tag, " R2 quiet l3"}, int'(res_l3), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 valid after reset", int'(res_valid), 0);
    check("R11 l3 after reset", int'(res_l3), 0);

    for (int v = 0; v < NV; v++) begin
      build(TV[v]);
      send(1'b0);
      expect_res(TV[v], $sformatf("vec%0d", v));
      repeat (2) @(negedge clk);
    end

    // R12: bubble inside a good IPv4 TCP frame
    build(TV[0]);
    send(1'b1);
    expect_res(TV[0], "r12_bubble");

    // R9: trailing bytes differ but results stay clean
    build(TV[1]);
    for (int i = n - 6; i < n; i++) frm[i] = 8'(i * 3);
    send(1'b0);
    expect_res(TV[1], "r9_trailer");

    // R3: IHL 6 header with a corrupted option byte
    build(TV[4]);
    frm[14 + 21] = frm[14 + 21] ^ 8'h10;
    send(1'b0);
    check("R3 option byte corrupt", int'(res_hdr_err), 1);
    @(negedge clk);

    // R7: offset fragment with good bytes is still unchecked
    build('{2'd1, 8'd17, 16'd20, 4'd5, 2'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0});
    send(1'b0);
    check("R7 offset fragment checked", int'(res_checked), 0);
    check("R7 offset fragment l4_err", int'(res_l4_err), 0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule